// File: doc/BRIEF.md
# Load-Adaptive Dead-Time Calculator

This block turns a digitized load-current reading and an adaptation setpoint into two dead-time counts, one for each leg of a full bridge. The dead time follows the load: as the current reading rises above the setpoint, an internal control level rises linearly from a floor. The dead time is a per-leg scale divided by that level, plus a fixed offset. Heavy load therefore gives short dead time, and light load gives long dead time.

A sample strobe captures the two codes into a held index. The reciprocal comes from a constant table built at elaboration, so there is no runtime divider. The bridge PWM generator gives a period strobe when its ramp resets. Both outputs load only on that strobe, so a dead time never changes inside a switching period.

Top module: `deadtime_adapt`

## Requirements
- R1: After reset both dead-time outputs read 0 and the held level index is 0, the longest-delay setting.
- R2: Codes are in units of 1/64 V. The control level in those units is 32 + floor(3*(cs-set)/4). The held index is floor((level-32)/2), saturated at 63.
- R3: When the setpoint code is greater than or equal to the current-sense code, the level stays at its floor of 32 and the index is 0. The delay is then 2*scale + offset, its maximum.
- R4: Each leg's dead time is floor(scale * floor(8192/(16+index)) / 256) + OFFSET_CNT. The default OFFSET_CNT is 25. Each leg uses its own scale input.
- R5: The outputs change only in the cycle after a period strobe. Between strobes they hold, even when the scale inputs change.
- R6: The current-sense and setpoint codes are captured only on a cycle with the sample strobe high. Code changes without that strobe do not reach the outputs.
- R7: With the setpoint at 0, moving the current-sense code from 0 to 128 (0 V to 2.0 V) reduces the dead time above the offset by exactly 4:1. This holds when the scale is a multiple of 2.
- R8: Current-sense codes far above the setpoint clamp the index at 63. For example, code 255 with setpoint 0 gives the index-63 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Captures cs_code and set_code |
| cs_code | input | 8 | Digitized current sense, 1/64 V per LSB |
| set_code | input | 8 | Adaptation setpoint, 1/64 V per LSB |
| scale_ab | input | 10 | Delay scale for leg AB, in counts per volt of level |
| scale_cd | input | 10 | Delay scale for leg CD, in counts per volt of level |
| period_go | input | 1 | Ramp-reset strobe that loads new dead times |
| dt_ab | output | 12 | Dead-time count for leg AB |
| dt_cd | output | 12 | Dead-time count for leg CD |

## Verification
The assertions assume that the scale inputs are settled in the cycle a period strobe is given. This is because the upper bound on a new output is checked against the scale seen at that edge. They also assume that the setpoint and current-sense codes are valid whenever the sample strobe is high. The stimulus changes scales and codes only on falling clock edges and keeps each strobe to a single cycle. It also sets up every code pair before it issues the strobe that uses it.

// File: rtl/dt_pkg.sv
package dt_pkg;
    parameter int CODE_W   = 8;
    parameter int SCALE_W  = 10;
    parameter int IDX_W    = 6;
    parameter int RECIP_F  = 8;
    parameter int RECIP_W  = RECIP_F + 2;
    parameter int DT_W     = SCALE_W + 2;
    parameter int LVL_BASE = 32;   // 0.5 V in 1/64 V units

    // reciprocal of level (32 + 2*i)/64 V, fixed point with RECIP_F fraction bits
    function automatic logic [RECIP_W-1:0] recip_of(input int i);
        return RECIP_W'((1 << (RECIP_F + 5)) / (16 + i));
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DT_W-1:0]  dt_ab;
        logic [DT_W-1:0]  dt_cd;
    } dt_state_t;
endpackage

// File: rtl/dt_level.sv
module dt_level
    import dt_pkg::*;
(
    input  logic [CODE_W-1:0] cs_code,
    input  logic [CODE_W-1:0] set_code,
    output logic [IDX_W-1:0]  idx
);
    localparam int LVL_W   = CODE_W + 3;
    localparam int IDX_MAX = (1 << IDX_W) - 1;

    logic [CODE_W-1:0] diff;
    logic [LVL_W-1:0]  level;
    logic [LVL_W-1:0]  raw_idx;

    always_comb begin
        // setpoint above current sense saturates to zero difference
        diff    = (cs_code > set_code) ? cs_code - set_code : '0;
        level   = LVL_W'(LVL_BASE) + ((LVL_W'(diff) * LVL_W'(3)) >> 2);
        raw_idx = (level - LVL_W'(LVL_BASE)) >> 1;
        idx     = (raw_idx > LVL_W'(IDX_MAX)) ? IDX_W'(IDX_MAX) : raw_idx[IDX_W-1:0];
    end
endmodule

// File: rtl/dt_recip_rom.sv
module dt_recip_rom
    import dt_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [RECIP_W-1:0] recip
);
    localparam int DEPTH = 1 << IDX_W;

    logic [RECIP_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [RECIP_W-1:0] ENTRY = recip_of(g);
        assign rom[g] = ENTRY;
    end

    assign recip = rom[idx];
endmodule

// File: rtl/dt_leg_scale.sv
module dt_leg_scale
    import dt_pkg::*;
#(
    parameter int OFFSET_CNT = 25
) (
    input  logic [SCALE_W-1:0] scale,
    input  logic [RECIP_W-1:0] recip,
    output logic [DT_W-1:0]    dt
);
    localparam int PROD_W = SCALE_W + RECIP_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(scale) * PROD_W'(recip);
        dt   = DT_W'(prod >> RECIP_F) + DT_W'(OFFSET_CNT);
    end
endmodule

// File: rtl/deadtime_adapt.sv
module deadtime_adapt
    import dt_pkg::*;
#(
    parameter int OFFSET_CNT = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_vld,
    input  logic [CODE_W-1:0]  cs_code,
    input  logic [CODE_W-1:0]  set_code,
    input  logic [SCALE_W-1:0] scale_ab,
    input  logic [SCALE_W-1:0] scale_cd,
    input  logic               period_go,
    output logic [DT_W-1:0]    dt_ab,
    output logic [DT_W-1:0]    dt_cd
);
    localparam int N_LEG = 2;

    dt_state_t          st_d, st_q;
    logic [IDX_W-1:0]   idx_new;
    logic [RECIP_W-1:0] recip;
    logic [SCALE_W-1:0] leg_scale [N_LEG];
    logic [DT_W-1:0]    leg_dt    [N_LEG];

    dt_level u_level (
        .cs_code  (cs_code),
        .set_code (set_code),
        .idx      (idx_new)
    );

    dt_recip_rom u_rom (
        .idx   (st_q.idx),
        .recip (recip)
    );

    assign leg_scale[0] = scale_ab;
    assign leg_scale[1] = scale_cd;

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        dt_leg_scale #(.OFFSET_CNT(OFFSET_CNT)) u_leg (
            .scale (leg_scale[g]),
            .recip (recip),
            .dt    (leg_dt[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (sample_vld) st_d.idx = idx_new;
        if (period_go) begin
            st_d.dt_ab = leg_dt[0];
            st_d.dt_cd = leg_dt[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dt_ab = st_q.dt_ab;
    assign dt_cd = st_q.dt_cd;

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !period_go |=> ($stable(dt_ab) && $stable(dt_cd))); // R5
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(st_q.idx)); // R6
    AST_SET_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && set_code >= cs_code) |=> st_q.idx == '0); // R3
    AST_OFFSET_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        period_go |=> (dt_ab >= DT_W'(OFFSET_CNT) && dt_cd >= DT_W'(OFFSET_CNT))); // R4
    AST_SCALE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        period_go |=> (dt_ab <= DT_W'($past(scale_ab)) * DT_W'(2) + DT_W'(OFFSET_CNT))); // R4
endmodule

// File: tb/deadtime_adapt_tb.sv
module deadtime_adapt_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [7:0] cs_code = '0;
    logic [7:0] set_code = '0;
    logic [9:0] scale_ab = '0;
    logic [9:0] scale_cd = '0;
    logic       period_go = 1'b0;
    logic [11:0] dt_ab, dt_cd;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    deadtime_adapt u_dut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .cs_code(cs_code), .set_code(set_code),
        .scale_ab(scale_ab), .scale_cd(scale_cd),
        .period_go(period_go), .dt_ab(dt_ab), .dt_cd(dt_cd)
    );

    function automatic int exp_dt(int cs, int st, int sc);
        int diff = (cs > st) ? cs - st : 0;
        int lvl  = 32 + (3 * diff) / 4;
        int ix   = (lvl - 32) / 2;
        if (ix > 63) ix = 63;
        return (sc * (8192 / (16 + ix))) / 256 + 25;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sample codes, then strobe period; outputs checked after the strobe edge
    task automatic load(int cs, int st, int sa, int sc);
        @(negedge clk);
        cs_code = 8'(cs); set_code = 8'(st); scale_ab = 10'(sa); scale_cd = 10'(sc);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0; period_go = 1'b1;
        @(negedge clk);
        period_go = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 dt_ab", int'(dt_ab), 0);
        check("R1 dt_cd", int'(dt_cd), 0);
        // index 0 after reset: strobe without sample gives max delay
        @(negedge clk); scale_ab = 10'd100; scale_cd = 10'd50; period_go = 1'b1;
        @(negedge clk); period_go = 1'b0;
        check("R1 idx0 ab", int'(dt_ab), 225);
        check("R1 idx0 cd", int'(dt_cd), 125);
    endtask

    task automatic t_points;
        load(40, 8, 100, 200);
        check("R2 ab", int'(dt_ab), exp_dt(40, 8, 100));
        check("R4 cd", int'(dt_cd), exp_dt(40, 8, 200));
        load(97, 13, 333, 77);
        check("R2 odd ab", int'(dt_ab), exp_dt(97, 13, 333));
        check("R4 odd cd", int'(dt_cd), exp_dt(97, 13, 77));
    endtask

    task automatic t_setpoint;
        load(50, 90, 100, 200);
        check("R3 set>cs ab", int'(dt_ab), 225);
        check("R3 set>cs cd", int'(dt_cd), 425);
        load(70, 70, 100, 200);
        check("R3 set==cs ab", int'(dt_ab), 225);
    endtask

    task automatic t_span;
        int lo, hi;
        load(0, 0, 100, 100);
        hi = int'(dt_ab);
        load(128, 0, 100, 100);
        lo = int'(dt_ab);
        check("R7 light", hi, 225);
        check("R7 heavy", lo, 75);
        check("R7 ratio", (hi - 25), 4 * (lo - 25));
    endtask

    task automatic t_clamp;
        load(255, 0, 100, 1000);
        check("R8 ab", int'(dt_ab), 65);
        check("R8 cd", int'(dt_cd), (1000 * 103) / 256 + 25);
    endtask

    task automatic t_hold;
        load(64, 0, 100, 100);
        @(negedge clk); scale_ab = 10'd500; scale_cd = 10'd7;
        repeat (3) @(negedge clk);
        check("R5 hold ab", int'(dt_ab), exp_dt(64, 0, 100));
        check("R5 hold cd", int'(dt_cd), exp_dt(64, 0, 100));
        period_go = 1'b1;
        @(negedge clk); period_go = 1'b0;
        check("R5 update ab", int'(dt_ab), exp_dt(64, 0, 500));
    endtask

    task automatic t_ignore;
        load(20, 0, 100, 100);
        @(negedge clk); cs_code = 8'd200; set_code = 8'd0;
        @(negedge clk); period_go = 1'b1;
        @(negedge clk); period_go = 1'b0;
        check("R6 no sample", int'(dt_ab), exp_dt(20, 0, 100));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_points;
        t_setpoint;
        t_span;
        t_clamp;
        t_hold;
        t_ignore;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule